// File: doc/BRIEF.md
# Serial Register Access Port with Selectable Bit Order

This block is the target end of a two-byte serial link. A host uses it to read and write a 64-entry space of byte-wide registers. The host lowers the active-low select, clocks in a command byte and then one data byte, and raises the select again. The command byte carries the transfer direction first, then six address bits, then one bit that is ignored. On a write, the second byte is the value to store. On a read, the block returns the stored value during the second byte.

A static `mode` input chooses the wire arrangement. With `mode` = 0 the address and data travel least-significant bit first over one shared data line. In that case `sdi` is the line itself, and the block drives it from `sdo` only while `sdo_oe` is high. With `mode` = 1 the address and data travel most-significant bit first, and input and output use separate lines.

The register storage sits outside the block. It is reached through a synchronous strobe port that is clocked by `sclk`.

Top module: `serial_reg_port`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `sdo_oe`, `rf_wr` and `rf_rd` are all 0.
- R2: With `mode`=0, the bits sampled on rising `sclk` edges 1..16 are: direction (1=read, 0=write), address bit 0 up to bit 5, one ignored bit, then data bit 0 up to bit 7. A write asserts `rf_wr` with that address and data so that the store happens on rising edge 16.
- R3: With `mode`=1 the order is: direction, address bit 5 down to bit 0, one ignored bit, then data bit 7 down to bit 0. The write behaves as in R2.
- R4: On a read, `rf_rd` is high for exactly the cycle that ends with rising edge 8, with the decoded address on `rf_addr`. `rf_rdata` is taken as registered at that edge.
- R5: With `mode`=0, read data goes out bit 0 first. Each bit changes on a falling `sclk` edge, and the first bit appears on the falling edge that follows rising edge 8.
- R6: With `mode`=1, read data goes out bit 7 first, with the same falling-edge timing as R5.
- R7: `sdo_oe` is high only in a read frame, from the falling edge after rising edge 8 until the falling edge after rising edge 16. It is low throughout every command byte and every write.
- R8: Rising clock edges after the 16th in the same frame start no new command, cause no register access and do not drive the output.
- R9: Raising `cs_n` before the frame completes drops `sdo_oe` at once, performs no write, and leaves the next frame to start from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mode | input | 1 | 0: LSB-first on a shared line; 1: MSB-first on split lines |
| sdi | input | 1 | Serial input (the shared line when mode=0) |
| sdo | output | 1 | Serial output bit |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| rf_addr | output | 6 | Register address |
| rf_wr | output | 1 | Write strobe, taken on rising `sclk` |
| rf_wdata | output | 8 | Write data |
| rf_rd | output | 1 | Read strobe, taken on rising `sclk` |
| rf_rdata | input | 8 | Registered read data from storage |

## Verification
A bit counter that is off by one cycle shows up in the very same frame. It lands a write in the wrong cycle, moves the read strobe away from the 8th edge, or shifts the returned byte by one position. Any of these is visible before `cs_n` rises. A wrong slot mapping for one mode swaps address or data bits, and that swap appears at the first read-back of a register written in the other mode. If the frame state is not cleared on an early `cs_n` rise, `sdo_oe` stays high for the next few nanoseconds, or a phantom write shows up later on `rf_wr`.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Position of an address bit given its frame slot (slot 1 is the first address bit).
  function automatic int addr_slot(int pos, logic msb_first, int aw);
    return msb_first ? (aw - pos) : (pos - 1);
  endfunction

  // Position of a data bit given its order k within the data byte (k=0 travels first).
  function automatic int data_slot(int k, logic msb_first, int dw);
    return msb_first ? (dw - 1 - k) : k;
  endfunction
endpackage

// File: rtl/sp_bitcount.sv
module sp_bitcount #(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int FRAME = AW + DW + 2,
  localparam int CW = $clog2(FRAME + 1)
) (
  input  logic          sclk,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME);

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) cnt <= '0;
    else if (cnt != C_FRAME) cnt <= cnt + 1'b1;
  end

  // R8
  cnt_saturate_chk: assert property (@(posedge sclk) disable iff (clr) cnt <= C_FRAME);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int FRAME = AW + DW + 2,
  localparam int CW = $clog2(FRAME + 1),
  localparam int AIW = $clog2(AW),
  localparam int DIW = $clog2(DW)
) (
  input  logic          sclk,
  input  logic          clr,
  input  logic          msb_first,
  input  logic          sdi,
  input  logic [CW-1:0] cnt,
  output logic          is_read,
  output logic [AW-1:0] addr,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [DW-1:0] wdata
);
  localparam logic [CW-1:0] C_ADDR_END = CW'(AW);
  localparam logic [CW-1:0] C_CMD      = CW'(AW + 2);
  localparam logic [CW-1:0] C_LAST     = CW'(FRAME - 1);

  logic [DW-1:0]  dbuf;
  logic [AIW-1:0] a_idx;
  logic [DIW-1:0] d_idx, last_idx;

  always_comb begin
    a_idx    = AIW'(addr_slot(int'(cnt), msb_first, AW));
    d_idx    = DIW'(data_slot(int'(cnt) - (AW + 2), msb_first, DW));
    last_idx = DIW'(data_slot(DW - 1, msb_first, DW));
  end

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      is_read <= 1'b0;
      addr    <= '0;
      dbuf    <= '0;
    end else if (cnt == '0) begin
      is_read <= sdi;
    end else if (cnt <= C_ADDR_END) begin
      addr[a_idx] <= sdi;
    end else if (cnt >= C_CMD && cnt < C_LAST) begin
      dbuf[d_idx] <= sdi;
    end
  end

  // The final data bit is still on the line when storage samples it.
  always_comb begin
    wdata           = dbuf;
    wdata[last_idx] = sdi;
  end

  assign wr_stb = !clr && !is_read && (cnt == C_LAST);
  assign rd_stb = !clr &&  is_read && (cnt == C_CMD - 1'b1);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int FRAME = AW + DW + 2,
  localparam int CW = $clog2(FRAME + 1),
  localparam int DIW = $clog2(DW)
) (
  input  logic          sclk,
  input  logic          clr,
  input  logic          msb_first,
  input  logic [CW-1:0] cnt,
  input  logic          is_read,
  input  logic [DW-1:0] rdata,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam logic [CW-1:0] C_CMD   = CW'(AW + 2);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME);

  logic [DW-1:0]  hold, src;
  logic [DIW-1:0] o_idx;
  logic           in_window;

  always_comb begin
    in_window = is_read && cnt >= C_CMD && cnt < C_FRAME;
    src       = (cnt == C_CMD) ? rdata : hold;
    o_idx     = DIW'(data_slot(int'(cnt) - (AW + 2), msb_first, DW));
  end

  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      hold   <= '0;
    end else if (in_window) begin
      sdo_oe <= 1'b1;
      sdo    <= src[o_idx];
      if (cnt == C_CMD) hold <= rdata;
    end else begin
      sdo_oe <= 1'b0;
      sdo    <= 1'b0;
    end
  end

  // R7
  oe_window_chk: assert property (@(posedge sclk) disable iff (clr)
    sdo_oe |-> (is_read && cnt >= C_CMD && cnt < C_FRAME));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mode,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_rd,
  input  logic [DW-1:0] rf_rdata
);
  localparam int FRAME = AW + DW + 2;
  localparam int CW = $clog2(FRAME + 1);

  logic          frame_clr;
  logic [CW-1:0] bit_cnt;
  logic          is_read;

  assign frame_clr = !rst_n || cs_n;

  sp_bitcount #(.AW(AW), .DW(DW)) u_cnt (
    .sclk(sclk), .clr(frame_clr), .cnt(bit_cnt)
  );

  sp_rx #(.AW(AW), .DW(DW)) u_rx (
    .sclk(sclk), .clr(frame_clr), .msb_first(mode), .sdi(sdi), .cnt(bit_cnt),
    .is_read(is_read), .addr(rf_addr), .wr_stb(rf_wr), .rd_stb(rf_rd),
    .wdata(rf_wdata)
  );

  sp_tx #(.AW(AW), .DW(DW)) u_tx (
    .sclk(sclk), .clr(frame_clr), .msb_first(mode), .cnt(bit_cnt),
    .is_read(is_read), .rdata(rf_rdata), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // R7
  wr_no_drive_chk: assert property (@(posedge sclk) disable iff (frame_clr)
    rf_wr |-> !sdo_oe);
  // R4
  rd_before_drive_chk: assert property (@(posedge sclk) disable iff (frame_clr)
    rf_rd |-> !sdo_oe);
  // R1
  idle_quiet_chk: assert property (@(posedge sclk)
    frame_clr |-> (!rf_wr && !rf_rd));
endmodule

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int CLK_PERIOD = 20;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QTR  = CLK_PERIOD / 4;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mode = 1'b0, sdi_m = 1'b0;
  logic sdo, sdo_oe, rf_wr, rf_rd, sdi_w;
  logic [5:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];
  logic [13:0] wq[$];
  logic [7:0]  rq[$];
  logic [7:0]  rbyte;
  int n_chk = 0, n_err = 0, bit_no = 0;
  bit in_frame = 0, cur_read = 0, cur_msb = 0, finished = 0;
  logic [5:0] cur_addr;
  event sample_ev;

  assign sdi_w = (!mode && sdo_oe) ? sdo : sdi_m;

  serial_reg_port u0 (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mode(mode), .sdi(sdi_w),
    .sdo(sdo), .sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_wr(rf_wr),
    .rf_wdata(rf_wdata), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
  );

  // Register file model
  always @(posedge sclk) begin
    if (rf_wr) mem[rf_addr] <= rf_wdata;
    if (rf_rd) rf_rdata <= mem[rf_addr];
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Monitor / scoreboard
  always @(sample_ev) begin
    logic exp_oe, exp_wr, exp_rd, line;
    logic [13:0] w;
    exp_oe = cur_read && bit_no >= 8 && bit_no <= 15;
    exp_wr = !cur_read && bit_no == 15;
    exp_rd = cur_read && bit_no == 7;
    check(sdo_oe == exp_oe, "R7 oe", sdo_oe, exp_oe);
    check(rf_wr == exp_wr, (bit_no > 15) ? "R8 wr" : "R2/R3 wr", rf_wr, exp_wr);
    check(rf_rd == exp_rd, (bit_no > 15) ? "R8 rd" : "R4 rd", rf_rd, exp_rd);
    if (rf_rd) check(rf_addr == cur_addr, "R4 addr", rf_addr, cur_addr);
    if (rf_wr) begin
      if (wq.size() == 0) check(0, "R8 stray write", rf_addr, 0);
      else begin
        w = wq.pop_front();
        check({rf_addr, rf_wdata} == w, cur_msb ? "R3 write" : "R2 write",
              {rf_addr, rf_wdata}, w);
      end
    end
    if (exp_oe) begin
      line = mode ? sdo : sdi_w;
      rbyte[cur_msb ? (15 - bit_no) : (bit_no - 8)] = line;
      if (bit_no == 15 && rq.size() != 0) begin
        w = {6'd0, rq.pop_front()};
        check(rbyte == w[7:0], cur_msb ? "R6 read" : "R5 read", rbyte, w[7:0]);
      end
    end
  end

  task automatic frame(bit msb, bit rd, logic [5:0] a, logic [7:0] d, int nbits, bit push);
    logic b[16];
    mode = msb; cur_read = rd; cur_msb = msb; cur_addr = a;
    b[0] = rd; b[7] = 1'b0;
    for (int i = 1; i <= 6; i++) b[i] = msb ? a[6 - i] : a[i - 1];
    for (int k = 0; k < 8; k++) b[8 + k] = msb ? d[7 - k] : d[k];
    if (push) begin
      if (rd) rq.push_back(ref_mem[a]);
      else begin wq.push_back({a, d}); ref_mem[a] = d; end
    end
    #QTR cs_n = 1'b0; in_frame = 1;
    for (int i = 0; i < nbits; i++) begin
      sdi_m = b[i % 16]; bit_no = i;
      #QTR -> sample_ev;
      #QTR sclk = 1'b1;
      #HALF sclk = 1'b0;
    end
    #QTR cs_n = 1'b1; in_frame = 0;
    #1 check(sdo_oe == 1'b0, "R9 oe release", sdo_oe, 0);
    check(rf_wr == 1'b0 && rf_rd == 1'b0, "R1 idle strobes", {rf_wr, rf_rd}, 0);
    #HALF;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    #3;
    // R1 reset state
    check(sdo_oe == 0, "R1 reset oe", sdo_oe, 0);
    check(rf_wr == 0 && rf_rd == 0, "R1 reset strobes", {rf_wr, rf_rd}, 0);
    #CLK_PERIOD rst_n = 1'b1;
    #CLK_PERIOD;
    // R2 / R5: LSB-first write then read back
    frame(0, 0, 6'h05, 8'h3C, 16, 1);
    frame(0, 0, 6'h2A, 8'h81, 16, 1);
    frame(0, 1, 6'h05, 8'h00, 16, 1);
    frame(0, 1, 6'h2A, 8'h00, 16, 1);
    // R3 / R6: MSB-first, and cross-mode read-back
    frame(1, 0, 6'h11, 8'hC5, 16, 1);
    frame(1, 1, 6'h11, 8'h00, 16, 1);
    frame(1, 1, 6'h05, 8'h00, 16, 1);
    frame(0, 1, 6'h11, 8'h00, 16, 1);
    frame(1, 0, 6'h3F, 8'h01, 16, 1);
    frame(0, 1, 6'h3F, 8'h00, 16, 1);
    frame(0, 0, 6'h00, 8'hFE, 16, 1);
    frame(1, 1, 6'h00, 8'h00, 16, 1);
    frame(1, 1, 6'h2A, 8'h00, 16, 1);
    // R9: aborted write leaves the register intact; aborted read releases the line
    frame(0, 0, 6'h05, 8'h00, 12, 0);
    frame(0, 1, 6'h05, 8'h00, 16, 1);
    frame(1, 1, 6'h11, 8'h00, 10, 0);
    frame(0, 1, 6'h2A, 8'h00, 10, 0);
    frame(1, 1, 6'h11, 8'h00, 16, 1);
    // R8: extra clocks after a full frame
    frame(0, 0, 6'h07, 8'h55, 32, 1);
    frame(1, 1, 6'h07, 8'h00, 24, 1);
    frame(1, 0, 6'h09, 8'hAA, 32, 1);
    frame(0, 1, 6'h09, 8'h00, 16, 1);
    check(wq.size() == 0, "R2/R3 pending writes", wq.size(), 0);
    check(rq.size() == 0, "R5/R6 pending reads", rq.size(), 0);
    finish_run();
  end
endmodule